// File: doc/BRIEF.md
# Nesting Priority Interrupt Controller

The block gathers interrupt requests from four source classes and presents the processor with one request line and a 2-bit vector naming the winner. The four classes are hardware failure (for example a parity fault or a supply loss), program exception (for example arithmetic overflow or division by zero), timer, and I/O completion or error. A rising edge on a source line latches a pending bit. The bit stays set until the processor acknowledges that source, so no event is lost while the processor is busy.

The processor acknowledges the presented vector with `int_ack`, which moves the source from pending into service. It signals the end of a handler with `svc_done`. A run-time input picks one of two modes. In sequential mode nothing is presented while any handler runs. In nested mode a strictly higher class may preempt the handler in service. The lower handler resumes once the higher one completes. A small state machine tracks service depth: `SV_IDLE` (nothing in service), `SV_SINGLE` (one level) and `SV_STACKED` (two or more levels). Its transitions are: acknowledge from idle (idle to single), preempt (single to stacked), complete (single to idle), unwind (stacked to single when depth is two) and partial unwind (stacked stays stacked).

Top module: `irq_nest_ctrl`

## Requirements
- R1: After reset `irq` is low, no source is pending and no level is in service.
- R2: A source becomes pending on a 0-to-1 transition of its `src_req` bit. A level held high after acknowledge does not pend it again; only a new rising edge does.
- R3: Priority is fixed by bit position. Bit 3 (hardware failure) is highest, then bit 2 (program), bit 1 (timer) and bit 0 (I/O). While `irq` is high, `irq_vec` carries the bit index of the highest-priority pending source.
- R4: With `nest_mode` = 0, `irq` stays low while any level is in service, whatever arrives.
- R5: Requests that arrive during service stay pending and are presented after service ends, highest priority first.
- R6: With `nest_mode` = 1, a pending source is presented during service only if its priority is strictly above the highest level in service.
- R7: A `svc_done` pulse clears only the highest-priority level in service, so any lower preempted level stays in service and keeps blocking requests at or below it.
- R8: `int_ack` with `irq` high clears the presented source's pending bit and marks its level in service. `int_ack` with `irq` low has no effect.
- R9: If a source sees a new rising edge in the same cycle it is acknowledged, it stays pending.
- R10: `svc_done` with nothing in service has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_req | input | 4 | Request lines; bit 3 hardware failure, 2 program, 1 timer, 0 I/O |
| nest_mode | input | 1 | 1 = nested preemption, 0 = sequential |
| int_ack | input | 1 | Acknowledge of the presented vector, one cycle |
| svc_done | input | 1 | End-of-service strobe, one cycle |
| irq | output | 1 | Request to the processor |
| irq_vec | output | 2 | Index of the presented source, valid while `irq` is high |

## Verification
The hardest state to reach is a rising edge that lands in the very cycle its own source is acknowledged. The source must already be pending from an earlier edge. Its line must then drop and rise again exactly when the acknowledge is driven. The stimulus builds this on purpose and then confirms the source is still presented after the handler finishes. A three-deep nested stack, unwound one completion at a time with a lower request waiting, is also scripted. So are mode switches in the middle of service. A randomized tail then mixes edges, strobes and mode flips against the behavioural model.

// File: rtl/irq_pkg.sv
package irq_pkg;
    typedef enum logic [1:0] {
        SV_IDLE    = 2'd0,
        SV_SINGLE  = 2'd1,
        SV_STACKED = 2'd2
    } svc_state_e;
endpackage

// File: rtl/irq_edge_latch.sv
module irq_edge_latch #(
    parameter int N_SRC = 4,
    localparam int IDX_W = $clog2(N_SRC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_req,
    input  logic             ack_fire,
    input  logic [IDX_W-1:0] ack_idx,
    output logic [N_SRC-1:0] pend,
    output logic [N_SRC-1:0] rise
);
    logic [N_SRC-1:0] req_q;
    logic [N_SRC-1:0] clr_mask;

    assign rise = src_req & ~req_q;

    always_comb begin
        clr_mask = '0;
        if (ack_fire) clr_mask[ack_idx] = 1'b1;
    end

    // a fresh edge wins over the clear so the event is kept
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q <= '0;
            pend  <= '0;
        end else begin
            req_q <= src_req;
            pend  <= (pend & ~clr_mask) | rise;
        end
    end
endmodule

// File: rtl/irq_svc_fsm.sv
module irq_svc_fsm
    import irq_pkg::*;
#(
    parameter int N_SRC = 4,
    localparam int IDX_W = $clog2(N_SRC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ack_fire,
    input  logic [IDX_W-1:0] ack_idx,
    input  logic             done,
    output svc_state_e       state,
    output logic [N_SRC-1:0] isr
);
    svc_state_e       state_n;
    logic [N_SRC-1:0] set_mask;
    logic [N_SRC-1:0] drop_mask;
    logic [N_SRC-1:0] isr_n;
    int unsigned      depth;

    always_comb begin
        set_mask = '0;
        if (ack_fire) set_mask[ack_idx] = 1'b1;
    end

    // end of service retires the highest level in service
    always_comb begin
        drop_mask = '0;
        if (done) begin
            for (int i = 0; i < N_SRC; i++) begin
                if (isr[i]) begin
                    drop_mask    = '0;
                    drop_mask[i] = 1'b1;
                end
            end
        end
    end

    assign isr_n = (isr & ~drop_mask) | set_mask;
    assign depth = $countones(isr);

    always_comb begin
        state_n = state;
        unique case (state)
            SV_IDLE: begin
                if (ack_fire) state_n = SV_SINGLE;                 // acknowledge
            end
            SV_SINGLE: begin
                if (ack_fire && !done)      state_n = SV_STACKED;  // preempt
                else if (done && !ack_fire) state_n = SV_IDLE;     // complete
            end
            SV_STACKED: begin
                if (done && !ack_fire && depth == 2) state_n = SV_SINGLE; // unwind
            end
            default: state_n = SV_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= SV_IDLE;
            isr   <= '0;
        end else begin
            state <= state_n;
            isr   <= isr_n;
        end
    end
endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel
    import irq_pkg::*;
#(
    parameter int N_SRC = 4,
    localparam int IDX_W = $clog2(N_SRC)
) (
    input  logic [N_SRC-1:0] pend,
    input  logic [N_SRC-1:0] isr,
    input  svc_state_e       state,
    input  logic             nest_mode,
    output logic             irq,
    output logic [IDX_W-1:0] vec
);
    logic             pend_any;
    logic             isr_any;
    logic [IDX_W-1:0] top_isr;
    logic             eligible;

    always_comb begin
        pend_any = 1'b0;
        vec      = '0;
        isr_any  = 1'b0;
        top_isr  = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (pend[i]) begin
                pend_any = 1'b1;
                vec      = IDX_W'(i);
            end
            if (isr[i]) begin
                isr_any = 1'b1;
                top_isr = IDX_W'(i);
            end
        end
    end

    always_comb begin
        unique case (state)
            SV_IDLE:    eligible = 1'b1;
            SV_SINGLE,
            SV_STACKED: eligible = nest_mode && (!isr_any || vec > top_isr);
            default:    eligible = 1'b0;
        endcase
    end

    assign irq = pend_any && eligible;
endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl
    import irq_pkg::*;
#(
    parameter int N_SRC = 4,
    localparam int IDX_W = $clog2(N_SRC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_req,
    input  logic             nest_mode,
    input  logic             int_ack,
    input  logic             svc_done,
    output logic             irq,
    output logic [IDX_W-1:0] irq_vec
);
    logic [N_SRC-1:0] pend;
    logic [N_SRC-1:0] rise;
    logic [N_SRC-1:0] isr;
    svc_state_e       state;
    logic             ack_fire;

    assign ack_fire = int_ack && irq;

    irq_edge_latch #(.N_SRC(N_SRC)) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_req  (src_req),
        .ack_fire (ack_fire),
        .ack_idx  (irq_vec),
        .pend     (pend),
        .rise     (rise)
    );

    irq_svc_fsm #(.N_SRC(N_SRC)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .ack_fire (ack_fire),
        .ack_idx  (irq_vec),
        .done     (svc_done),
        .state    (state),
        .isr      (isr)
    );

    irq_prio_sel #(.N_SRC(N_SRC)) u_sel (
        .pend      (pend),
        .isr       (isr),
        .state     (state),
        .nest_mode (nest_mode),
        .irq       (irq),
        .vec       (irq_vec)
    );
endmodule

// File: rtl/irq_nest_chk.sv
module irq_nest_chk #(
    parameter int N_SRC = 4,
    localparam int IDX_W = $clog2(N_SRC)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             nest_mode,
    input logic             int_ack,
    input logic             svc_done,
    input logic             irq,
    input logic [IDX_W-1:0] irq_vec,
    input logic [N_SRC-1:0] pend,
    input logic [N_SRC-1:0] rise,
    input logic [N_SRC-1:0] isr
);
    // R3
    vec_is_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> pend[irq_vec]);

    // R4
    seq_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!nest_mode && (|isr)) |-> !irq);

    // R8
    ack_enters_service_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int_ack && irq) |=> isr[$past(irq_vec)]);

    // R7
    done_drops_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_done && (|isr) && !(int_ack && irq))
            |=> ($countones(isr) + 1 == $countones($past(isr))));

    // R9
    edge_survives_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int_ack && irq && rise[irq_vec]) |=> pend[$past(irq_vec)]);
endmodule

bind irq_nest_ctrl irq_nest_chk #(.N_SRC(N_SRC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .nest_mode (nest_mode),
    .int_ack   (int_ack),
    .svc_done  (svc_done),
    .irq       (irq),
    .irq_vec   (irq_vec),
    .pend      (pend),
    .rise      (rise),
    .isr       (isr)
);

// File: tb/tb_irq_nest_ctrl.sv
`timescale 1ns/1ps
module tb_irq_nest_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] src_req = '0;
    logic       nest_mode = 1'b0;
    logic       int_ack = 1'b0;
    logic       svc_done = 1'b0;
    logic       irq;
    logic [1:0] irq_vec;

    int checks = 0;
    int fails  = 0;
    string tag = "R1";

    // behavioural reference
    bit m_pend [4];
    bit m_prev [4];
    int stk [$];

    always #2 clk = ~clk;

    irq_nest_ctrl dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_req   (src_req),
        .nest_mode (nest_mode),
        .int_ack   (int_ack),
        .svc_done  (svc_done),
        .irq       (irq),
        .irq_vec   (irq_vec)
    );

    function automatic int m_cand();
        int c = -1;
        for (int i = 0; i < 4; i++) if (m_pend[i]) c = i;
        return c;
    endfunction

    function automatic bit m_irq();
        int c = m_cand();
        if (c < 0) return 1'b0;
        if (stk.size() == 0) return 1'b1;
        return nest_mode && (c > stk[stk.size()-1]);
    endfunction

    task automatic model_update();
        bit fire = int_ack && m_irq();
        int c = m_cand();
        if (svc_done && stk.size() > 0) void'(stk.pop_back());
        if (fire) begin
            m_pend[c] = 1'b0;
            stk.push_back(c);
        end
        for (int i = 0; i < 4; i++) begin
            if (src_req[i] && !m_prev[i]) m_pend[i] = 1'b1;
            m_prev[i] = src_req[i];
        end
    endtask

    task automatic compare();
        bit ei = m_irq();
        int ec = m_cand();
        checks++;
        if (irq !== ei || (ei && irq_vec !== 2'(ec))) begin
            fails++;
            $display("FAIL %s: irq=%b vec=%0d expected irq=%b vec=%0d",
                     tag, irq, irq_vec, ei, ec);
        end
    endtask

    task automatic step(input logic [3:0] r, input bit a, input bit e);
        @(negedge clk);
        src_req  = r;
        int_ack  = a;
        svc_done = e;
        @(posedge clk);
        model_update();
        #1;
        compare();
    endtask

    initial begin
        #(4 * 20000);
        fails++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        checks++;
        if (irq !== 1'b0) begin
            fails++;
            $display("FAIL R1: irq=%b expected 0 in reset", irq);
        end
        @(negedge clk);
        rst_n = 1'b1;
        step(4'b0000, 0, 0);
        step(4'b0000, 0, 0);

        // R3: priority between I/O and program, sequential mode
        tag = "R3";
        step(4'b0101, 0, 0);
        step(4'b0101, 1, 0);
        // R4: hardware failure rises during service, must stay hidden
        tag = "R4";
        step(4'b1101, 0, 0);
        step(4'b1101, 0, 0);
        step(4'b1101, 0, 0);
        // R5: after completion, waiting ones come out highest first
        tag = "R5";
        step(4'b1101, 0, 1);
        step(4'b1101, 1, 0);
        step(4'b1101, 0, 1);
        step(4'b1101, 1, 0);
        step(4'b1101, 0, 1);
        // R2: levels still high, no new pending
        tag = "R2";
        step(4'b1101, 0, 0);
        step(4'b1101, 0, 0);
        step(4'b0000, 0, 0);
        step(4'b0001, 0, 0);
        step(4'b0001, 1, 0);
        step(4'b0001, 0, 1);
        step(4'b0000, 0, 0);

        // R6: nested preemption
        tag = "R6";
        nest_mode = 1'b1;
        step(4'b0010, 0, 0);
        step(4'b0010, 1, 0);
        step(4'b0011, 0, 0);
        step(4'b0011, 0, 0);
        step(4'b0111, 0, 0);
        step(4'b0111, 1, 0);
        step(4'b1111, 0, 0);
        step(4'b1111, 1, 0);
        step(4'b1111, 0, 0);
        // R7: unwind one level at a time, I/O stays blocked
        tag = "R7";
        step(4'b1111, 0, 1);
        step(4'b1111, 0, 0);
        step(4'b1111, 0, 1);
        step(4'b1111, 0, 0);
        step(4'b1111, 0, 1);
        step(4'b1111, 1, 0);
        step(4'b1111, 0, 1);
        step(4'b0000, 0, 0);

        // R9: new edge coincides with its own acknowledge
        tag = "R9";
        step(4'b0010, 0, 0);
        step(4'b0000, 0, 0);
        step(4'b0010, 1, 0);
        step(4'b0010, 0, 0);
        step(4'b0010, 0, 1);
        step(4'b0010, 1, 0);
        step(4'b0010, 0, 1);
        step(4'b0000, 0, 0);

        // R8: acknowledge with nothing presented is ignored
        tag = "R8";
        nest_mode = 1'b0;
        step(4'b0000, 1, 0);
        step(4'b0100, 0, 0);
        step(4'b0100, 0, 0);
        step(4'b0100, 1, 0);
        step(4'b0000, 0, 1);
        // R10: completion with empty service is ignored
        tag = "R10";
        step(4'b0000, 0, 1);
        step(4'b0001, 0, 0);
        step(4'b0001, 1, 0);
        step(4'b0000, 0, 1);

        // R4: mode drops to sequential during service
        tag = "R4";
        nest_mode = 1'b1;
        step(4'b0010, 0, 0);
        step(4'b0010, 1, 0);
        nest_mode = 1'b0;
        step(4'b1010, 0, 0);
        step(4'b1010, 0, 0);
        step(4'b1010, 0, 1);
        step(4'b1010, 1, 0);
        step(4'b0000, 0, 1);

        // R3: randomized mix
        tag = "R3";
        for (int k = 0; k < 600; k++) begin
            if (($urandom % 16) == 0) nest_mode = ~nest_mode;
            step(4'($urandom), ($urandom % 2) == 0, ($urandom % 4) == 0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule